// File: doc/BRIEF.md
# Two-Column Eligibility Picker for a Slotted Fair-Queuing Scheduler

The block keeps a grid of occupancy bits for queued packet segments. Each segment is filed under its start time, which picks the column, and under its finish time, which picks the row. All times are small integers counted in slots. The block never scans the whole grid. Within one slot it looks at only two columns:

- column `a`, the current system virtual time;
- column `b`, the start time of the segment being sent or just sent.

Inside each of these columns it takes the entry with the smallest finish time. A segment may only be chosen when its start time is no later than the virtual time. The winner of the two candidates is presented on a valid/ready output.

The stamps and the virtual time are computed outside the block. Each slot, the surrounding logic drives `vt_a` and `svc_b` and accepts the presented segment with `out_ready`. When the segment is accepted, its bit is cleared at that clock edge.

New segments enter through a valid/ready insert port. That port never applies back-pressure: `ins_ready` is always high. On the output side, `out_valid` does not depend on `out_ready`. While `out_ready` is low and nothing changes, the same segment stays presented. An insert whose cell is already occupied merges into that cell, because each cell is one bit.

Top module: `pfq2d_sched`

## Requirements
- R1: After reset every cell is empty, so `out_valid` is 0 for every value of `vt_a` and `svc_b`.
- R2: `ins_ready` is always 1. An insert with `ins_valid` high sets cell (`ins_start`, `ins_finish`), and the cell can be selected from the next cycle.
- R3: When column `vt_a` holds entries, its candidate is the lowest occupied row of that column, which is the smallest finish time.
- R4: Column `svc_b` gives a candidate only when `svc_b` <= `vt_a`. If `svc_b` > `vt_a`, its entries are not eligible and are never output.
- R5: Entries in any column other than `vt_a` and `svc_b` are never selected. With only such entries present, `out_valid` is 0.
- R6: When both columns give candidates, the one with the smaller finish time is output. On equal finish times the column-`vt_a` candidate wins. `out_from_b` is 1 exactly when the column-`svc_b` candidate is output, and `out_start` equals the column of the output candidate.
- R7: A handshake (`out_valid` and `out_ready` both 1) clears the output cell at that clock edge. With `out_ready` low, no cell is cleared and the same output holds while the inputs are unchanged.
- R8: An insert in the same cycle as a handshake does not change that cycle's output and takes effect from the next cycle. If it names the cell being cleared, the cell stays occupied.
- R9: The output follows `vt_a` and `svc_b` in the same cycle, with no register between them and the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Insert accepted (always 1) |
| ins_start | input | 4 | Start time (column) of inserted segment |
| ins_finish | input | 4 | Finish time (row) of inserted segment |
| vt_a | input | 4 | Current system virtual time |
| svc_b | input | 4 | Start time of the segment in service |
| out_valid | output | 1 | A selected segment is presented |
| out_ready | input | 1 | Consumer takes the presented segment |
| out_start | output | 4 | Start time of selected segment |
| out_finish | output | 4 | Finish time of selected segment |
| out_from_b | output | 1 | 1 when the selection came from column `svc_b` |

## Verification
An insert and an accepted transmit can land on the same clock edge, and they may even name the same cell. The bench provokes this in two ways. Directed cycles insert into the exact cell being sent, and into a different cell of the same column. Long mixed runs also raise `ins_valid` and `out_ready` together at random. Each cycle is judged against a bench-side grid model that clears the sent cell before setting the inserted one. The selection the RTL presents in the cycle must match the model's pick from the grid as it was before the edge.

// File: rtl/pfq2d_pkg.sv
package pfq2d_pkg;
  localparam int unsigned DEF_NCOL = 16;
  localparam int unsigned DEF_NROW = 16;

  typedef enum logic {
    SRC_COL_A = 1'b0,
    SRC_COL_B = 1'b1
  } cand_src_e;
endpackage

// File: rtl/pfq2d_bitmap.sv
// Occupancy grid: one bit per (start column, finish row).
// A clear and a set on the same edge: clear first, set second.
module pfq2d_bitmap #(
  parameter int unsigned NCOL = pfq2d_pkg::DEF_NCOL,
  parameter int unsigned NROW = pfq2d_pkg::DEF_NROW,
  localparam int unsigned CW = $clog2(NCOL),
  localparam int unsigned RW = $clog2(NROW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [CW-1:0]        set_col,
  input  logic [RW-1:0]        set_row,
  input  logic                 clr_en,
  input  logic [CW-1:0]        clr_col,
  input  logic [RW-1:0]        clr_row,
  output logic [NCOL*NROW-1:0] cells
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [NROW-1:0] col_q;
    logic [NROW-1:0] col_d;

    always_comb begin
      col_d = col_q;
      if (clr_en && (clr_col == CW'(c))) col_d[clr_row] = 1'b0;
      if (set_en && (set_col == CW'(c))) col_d[set_row] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) col_q <= '0;
      else        col_q <= col_d;
    end

    assign cells[c*NROW +: NROW] = col_q;
  end
endmodule

// File: rtl/pfq2d_colpick.sv
// Reads one column of the grid and finds its lowest occupied row.
module pfq2d_colpick #(
  parameter int unsigned NCOL = pfq2d_pkg::DEF_NCOL,
  parameter int unsigned NROW = pfq2d_pkg::DEF_NROW,
  localparam int unsigned CW = $clog2(NCOL),
  localparam int unsigned RW = $clog2(NROW)
) (
  input  logic [NCOL*NROW-1:0] cells,
  input  logic [CW-1:0]        col,
  output logic                 found,
  output logic [RW-1:0]        row
);
  logic [NROW-1:0] colvec [NCOL];
  logic [NROW-1:0] sel;

  for (genvar c = 0; c < NCOL; c++) begin : g_split
    assign colvec[c] = cells[c*NROW +: NROW];
  end

  assign sel   = colvec[col];
  assign found = |sel;

  always_comb begin
    row = '0;
    for (int r = NROW - 1; r >= 0; r--) begin
      if (sel[r]) row = RW'(r);
    end
  end
endmodule

// File: rtl/pfq2d_arbiter.sv
// Chooses between the column-a and column-b candidates.
module pfq2d_arbiter #(
  parameter int unsigned NROW = pfq2d_pkg::DEF_NROW,
  localparam int unsigned RW = $clog2(NROW)
) (
  input  logic                  a_found,
  input  logic [RW-1:0]         a_row,
  input  logic                  b_found,
  input  logic [RW-1:0]         b_row,
  input  logic                  b_elig,
  output logic                  valid,
  output pfq2d_pkg::cand_src_e  src,
  output logic [RW-1:0]         row
);
  import pfq2d_pkg::*;
  logic b_ok;

  assign b_ok  = b_found && b_elig;
  assign valid = a_found || b_ok;

  always_comb begin
    src = SRC_COL_A;
    if (b_ok && (!a_found || (b_row < a_row))) src = SRC_COL_B;
    row = (src == SRC_COL_B) ? b_row : a_row;
  end
endmodule

// File: rtl/pfq2d_sched.sv
module pfq2d_sched #(
  parameter int unsigned NCOL = pfq2d_pkg::DEF_NCOL,
  parameter int unsigned NROW = pfq2d_pkg::DEF_NROW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_valid,
  output logic                    ins_ready,
  input  logic [$clog2(NCOL)-1:0] ins_start,
  input  logic [$clog2(NROW)-1:0] ins_finish,
  input  logic [$clog2(NCOL)-1:0] vt_a,
  input  logic [$clog2(NCOL)-1:0] svc_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [$clog2(NCOL)-1:0] out_start,
  output logic [$clog2(NROW)-1:0] out_finish,
  output logic                    out_from_b
);
  import pfq2d_pkg::*;
  localparam int unsigned CW = $clog2(NCOL);
  localparam int unsigned RW = $clog2(NROW);

  logic [NCOL*NROW-1:0] cells;
  logic                 a_found, b_found, b_elig, fire;
  logic [RW-1:0]        a_row, b_row;
  cand_src_e            src;

  assign ins_ready = 1'b1;
  assign b_elig    = (svc_b <= vt_a);
  assign fire      = out_valid && out_ready;

  pfq2d_bitmap #(.NCOL(NCOL), .NROW(NROW)) u_grid (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ins_valid),
    .set_col (ins_start),
    .set_row (ins_finish),
    .clr_en  (fire),
    .clr_col (out_start),
    .clr_row (out_finish),
    .cells   (cells)
  );

  pfq2d_colpick #(.NCOL(NCOL), .NROW(NROW)) u_pick_a (
    .cells (cells),
    .col   (vt_a),
    .found (a_found),
    .row   (a_row)
  );

  pfq2d_colpick #(.NCOL(NCOL), .NROW(NROW)) u_pick_b (
    .cells (cells),
    .col   (svc_b),
    .found (b_found),
    .row   (b_row)
  );

  pfq2d_arbiter #(.NROW(NROW)) u_arb (
    .a_found (a_found),
    .a_row   (a_row),
    .b_found (b_found),
    .b_row   (b_row),
    .b_elig  (b_elig),
    .valid   (out_valid),
    .src     (src),
    .row     (out_finish)
  );

  assign out_from_b = (src == SRC_COL_B);
  assign out_start  = out_from_b ? svc_b : vt_a;

  logic [CW-1:0] unused_cw;
  assign unused_cw = '0;
endmodule

// File: rtl/pfq2d_sched_chk.sv
module pfq2d_sched_chk #(
  parameter int unsigned NCOL = 16,
  parameter int unsigned NROW = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ins_valid,
  input logic                    ins_ready,
  input logic [$clog2(NCOL)-1:0] vt_a,
  input logic [$clog2(NCOL)-1:0] svc_b,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [$clog2(NCOL)-1:0] out_start,
  input logic [$clog2(NROW)-1:0] out_finish,
  input logic                    out_from_b
);
  // R2: the insert port never stalls
  a_r2_ins_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_ready);

  // R4: a column-b pick needs b no later than the virtual time
  a_r4_b_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_from_b) |-> (svc_b <= vt_a));

  // R5: only columns a and b are ever output
  a_r5_only_two_cols: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_start == vt_a) || (out_start == svc_b)));

  // R6: the reported column matches the source flag
  a_r6_src_column: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_from_b ? (out_start == svc_b) : (out_start == vt_a)));

  // R7: with no handshake, no insert and steady a/b, the output holds
  a_r7_hold_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !ins_valid) |=>
      (!($stable(vt_a) && $stable(svc_b)) ||
       (out_valid && $stable(out_finish) && $stable(out_start))));
endmodule

bind pfq2d_sched pfq2d_sched_chk #(.NCOL(NCOL), .NROW(NROW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .vt_a       (vt_a),
  .svc_b      (svc_b),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_start  (out_start),
  .out_finish (out_finish),
  .out_from_b (out_from_b)
);

// File: tb/tb_pfq2d_sched.sv
module tb_pfq2d_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ins_valid, ins_ready, out_valid, out_ready, out_from_b;
  logic [3:0] ins_start, ins_finish, vt_a, svc_b, out_start, out_finish;

  int n_checks = 0;
  int n_fail   = 0;
  bit model [16][16];

  always #10 clk = ~clk;

  pfq2d_sched dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_start(ins_start), .ins_finish(ins_finish),
    .vt_a(vt_a), .svc_b(svc_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_start(out_start), .out_finish(out_finish), .out_from_b(out_from_b)
  );

  function automatic void mpick(input int a, input int b, output bit v,
                                output int s, output int f, output bit fb);
    int ra = -1;
    int rb = -1;
    for (int r = 15; r >= 0; r--) begin
      if (model[a][r]) ra = r;
      if (b <= a && model[b][r]) rb = r;
    end
    v = (ra >= 0) || (rb >= 0);
    fb = (rb >= 0) && (ra < 0 || rb < ra);
    s = fb ? b : a;
    f = fb ? rb : ra;
    if (!v) begin s = 0; f = 0; end
  endfunction

  task automatic chk(input string tag, input int a, input int b);
    bit v, fb;
    int s, f;
    mpick(a, b, v, s, f, fb);
    n_checks++;
    if (out_valid !== v || (v && (out_start !== 4'(s) || out_finish !== 4'(f) ||
        out_from_b !== fb))) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d got v=%0b s=%0d f=%0d fb=%0b exp v=%0b s=%0d f=%0d fb=%0b",
               tag, a, b, out_valid, out_start, out_finish, out_from_b, v, s, f, fb);
    end
  endtask

  // One cycle: drive at negedge, check the settled output, update the model as the edge will.
  task automatic cyc(input string tag, input bit iv, input int is, input int ifn,
                     input int a, input int b, input bit rdy);
    bit v, fb;
    int s, f;
    @(negedge clk);
    ins_valid = iv; ins_start = 4'(is); ins_finish = 4'(ifn);
    vt_a = 4'(a); svc_b = 4'(b); out_ready = rdy;
    #2;
    chk(tag, a, b);
    mpick(a, b, v, s, f, fb);
    if (v && rdy) model[s][f] = 1'b0;
    if (iv) model[is][ifn] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ins_valid = 0; out_ready = 0;
    foreach (model[c, r]) model[c][r] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        cyc(tag, 1'b0, 0, 0, a, b, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ins_valid = 0; ins_start = 0; ins_finish = 0;
    vt_a = 0; svc_b = 0; out_ready = 0;
    do_reset();

    // R1: empty after reset for every a/b
    sweep("R1");
    // R2: insert port always ready
    n_checks++;
    if (ins_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 ins_ready got %0b exp 1", ins_ready);
    end

    // R2/R3/R4/R5/R6/R9: random fills, each followed by a full a/b sweep
    for (int round = 0; round < 4; round++) begin
      do_reset();
      for (int k = 0; k < 6 + round * 8; k++)
        cyc("R2", 1'b1, int'($urandom_range(15)), int'($urandom_range(15)),
            int'($urandom_range(15)), int'($urandom_range(15)), 1'b0);
      sweep("R3_R4_R5_R6_R9");
    end

    // R5: only columns outside a and b are occupied
    do_reset();
    cyc("R5", 1'b1, 9, 2, 0, 0, 1'b0);
    cyc("R5", 1'b0, 0, 0, 5, 3, 1'b0);
    // R4: column b later than a is not eligible
    cyc("R4", 1'b0, 0, 0, 3, 9, 1'b0);
    cyc("R4", 1'b0, 0, 0, 9, 3, 1'b0);

    // R6: equal finish times, column a wins
    do_reset();
    cyc("R6", 1'b1, 2, 5, 0, 0, 1'b0);
    cyc("R6", 1'b1, 7, 5, 0, 0, 1'b0);
    cyc("R6", 1'b0, 0, 0, 7, 2, 1'b0);
    cyc("R6", 1'b1, 2, 3, 7, 2, 1'b0);
    cyc("R6", 1'b0, 0, 0, 7, 2, 1'b0);

    // R7: hold without ready, then drain column by handshakes
    cyc("R7", 1'b0, 0, 0, 7, 2, 1'b0);
    cyc("R7", 1'b0, 0, 0, 7, 2, 1'b0);
    for (int k = 0; k < 4; k++) cyc("R7", 1'b0, 0, 0, 7, 2, 1'b1);

    // R8: insert into the cell being sent, and into another cell of that column
    do_reset();
    cyc("R8", 1'b1, 3, 4, 0, 0, 1'b0);
    cyc("R8", 1'b1, 3, 4, 3, 3, 1'b1);
    cyc("R8", 1'b1, 3, 1, 3, 3, 1'b1);
    cyc("R8", 1'b0, 0, 0, 3, 3, 1'b0);

    // R7/R8: long mixed run with random inserts and handshakes
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      int a = int'($urandom_range(15));
      int b = (k % 3 == 0) ? a : int'($urandom_range(a));
      cyc("R7_R8", 1'($urandom_range(1)), int'($urandom_range(15)),
          int'($urandom_range(15)), a, b, 1'($urandom_range(1)));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule